// File: doc/BRIEF.md
# Dual Leaky Bucket Ingress Policer

This block meters the frames arriving on one ingress port against two leaky buckets and gives a verdict for each frame. The peak bucket decides whether a frame is forwarded or discarded. In dual-bucket operation a committed bucket also runs, and it marks frames that fit the peak budget but not the committed budget as out-of-profile. Each bucket drains by a configured rate once per prescaler tick. A frame that passes adds its cost to the fill level.

Four metering modes set what a frame costs. A byte-counting mode can add a configurable inter-frame gap, or leave it out. Two frame-counting modes use different resolutions. Burst sizes are given in fixed units per mode and clamp to a ceiling per mode. A coupling option lets the peak bucket also drain at the committed rate. A direct state write port loads either bucket's fill. Loading the all-ones state forces every later frame checked against that bucket to exceed it, which is the way to discard traffic. Setting the maximum peak rate with a zero peak burst and overshoot enabled lets all traffic pass.

Top module: `dlb_policer`

## Requirements
- R1: After reset both fill levels read 0 and `verdict_valid` is low.
- R2: Frame cost depends on `cfg_mode`. Code 0 costs `frm_len + cfg_gap`. Code 1 costs `frm_len`. Codes 2 (fine-grained frame count) and 3 (coarse frame count) each cost 10, because the fill counts tenths of a frame in those modes.
- R3: The burst threshold in fill units is min(burst,60)*4096 for codes 0 and 1, min(burst,127)*328 for code 2, and min(burst,61)*3 for code 3.
- R4: With `cfg_overshoot` high, a bucket is exceeded when its fill before the frame is greater than its threshold. With `cfg_overshoot` low, it is exceeded when the fill plus the frame cost is greater than the threshold.
- R5: The verdict appears one cycle after the `frm_valid` strobe. `verdict_drop` is high exactly when the peak bucket is exceeded. A dropped frame adds nothing to either bucket. A passed frame adds its cost to the peak fill.
- R6: With `cfg_dual` high, a passed frame that exceeds the committed bucket sets `verdict_oop` and leaves the committed fill unchanged. A frame within the committed bucket adds its cost to the committed fill. With `cfg_dual` low, `verdict_oop` stays low and frames never change the committed fill.
- R7: Once every `TICK_DIV` cycles each fill drops by its rate, saturating at 0. In code 2 the rate is multiplied by 100. In the other codes it is used as is.
- R8: With `cfg_dual` and `cfg_couple` both high, the peak bucket drains by `cfg_pir + cfg_cir`. Otherwise it drains by `cfg_pir`.
- R9: A state write takes priority over a frame or drain update in the same cycle, so the fill equals the written value one cycle later. A peak fill of all ones (0x7FFFFF) makes every frame drop in either overshoot setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Metering mode code (0..3) |
| cfg_gap | input | 5 | Gap bytes added per frame in mode 0 |
| cfg_overshoot | input | 1 | Judge on fill before the frame |
| cfg_dual | input | 1 | Enable committed bucket |
| cfg_couple | input | 1 | Add committed rate to peak drain |
| cfg_pir | input | 16 | Peak drain rate |
| cfg_pburst | input | 7 | Peak burst in mode units |
| cfg_cir | input | 16 | Committed drain rate |
| cfg_cburst | input | 7 | Committed burst in mode units |
| st_wr_peak | input | 1 | Load peak fill |
| st_wr_commit | input | 1 | Load committed fill |
| st_wdata | input | 23 | Fill value to load |
| frm_valid | input | 1 | Frame-end strobe |
| frm_len | input | 14 | Frame length in bytes |
| verdict_valid | output | 1 | Verdict strobe |
| verdict_drop | output | 1 | Frame discarded |
| verdict_oop | output | 1 | Frame out of committed profile |
| peak_fill | output | 23 | Peak bucket fill |
| commit_fill | output | 23 | Committed bucket fill |

## Verification
The properties assume that configuration inputs change only between frames. A verdict is tied to the `cfg_dual` value in the cycle of its strobe, and fill movements are attributed to a strobe or a write in the previous cycle. The bench changes configuration only while no frame is in flight. In the threshold sweep it holds both rates at zero, so drains cannot move a fill between the preload and the frame. It exercises the tick only in dedicated windows that are whole multiples of the prescaler period.

// File: rtl/dlb_pol_pkg.sv
package dlb_pol_pkg;
  typedef enum logic [1:0] {
    MODE_LINE   = 2'd0,
    MODE_DATA   = 2'd1,
    MODE_FRM_HI = 2'd2,
    MODE_FRM_LO = 2'd3
  } meter_mode_e;

  localparam int unsigned FRM_COST       = 10;
  localparam int unsigned BYTE_BURST_MUL = 4096;
  localparam int unsigned HI_BURST_MUL   = 328;
  localparam int unsigned LO_BURST_MUL   = 3;
  localparam int unsigned BYTE_BURST_MAX = 60;
  localparam int unsigned HI_BURST_MAX   = 127;
  localparam int unsigned LO_BURST_MAX   = 61;
  localparam int unsigned HI_RATE_MUL    = 100;
endpackage

// File: rtl/pol_tick.sv
module pol_tick #(
  parameter int TICK_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pol_meter.sv
module pol_meter
  import dlb_pol_pkg::*;
#(
  parameter int LEN_W   = 14,
  parameter int GAP_W   = 5,
  parameter int RATE_W  = 16,
  parameter int BURST_W = 7,
  parameter int STATE_W = 23
) (
  input  logic [1:0]         mode,
  input  logic [GAP_W-1:0]   gap,
  input  logic [LEN_W-1:0]   len,
  input  logic               dual,
  input  logic               couple,
  input  logic [RATE_W-1:0]  pir,
  input  logic [RATE_W-1:0]  cir,
  input  logic [BURST_W-1:0] pburst,
  input  logic [BURST_W-1:0] cburst,
  output logic [STATE_W-1:0] cost,
  output logic [STATE_W-1:0] peak_thr,
  output logic [STATE_W-1:0] commit_thr,
  output logic [STATE_W:0]   peak_drain,
  output logic [STATE_W:0]   commit_drain
);
  localparam int DW = STATE_W + 1;

  meter_mode_e m;
  logic [RATE_W:0] peak_rate;

  function automatic logic [STATE_W-1:0] burst_thr(input meter_mode_e md,
                                                   input logic [BURST_W-1:0] b);
    int unsigned bv, lim, mul;
    bv = 32'(b);
    case (md)
      MODE_FRM_HI: begin lim = HI_BURST_MAX;   mul = HI_BURST_MUL;   end
      MODE_FRM_LO: begin lim = LO_BURST_MAX;   mul = LO_BURST_MUL;   end
      default:     begin lim = BYTE_BURST_MAX; mul = BYTE_BURST_MUL; end
    endcase
    if (bv > lim) bv = lim;
    return STATE_W'(bv * mul);
  endfunction

  function automatic logic [DW-1:0] scale_rate(input meter_mode_e md,
                                               input logic [RATE_W:0] r);
    if (md == MODE_FRM_HI) return DW'(32'(r) * HI_RATE_MUL);
    return DW'(r);
  endfunction

  always_comb begin
    m = meter_mode_e'(mode);
    case (m)
      MODE_LINE: cost = STATE_W'(len) + STATE_W'(gap);
      MODE_DATA: cost = STATE_W'(len);
      default:   cost = STATE_W'(FRM_COST);
    endcase
    peak_thr     = burst_thr(m, pburst);
    commit_thr   = burst_thr(m, cburst);
    peak_rate    = {1'b0, pir} + ((dual && couple) ? {1'b0, cir} : '0);
    peak_drain   = scale_rate(m, peak_rate);
    commit_drain = scale_rate(m, {1'b0, cir});
  end
endmodule

// File: rtl/pol_bucket.sv
module pol_bucket #(
  parameter int STATE_W = 23
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [STATE_W:0]   drain,
  input  logic               add_en,
  input  logic [STATE_W-1:0] add_amt,
  input  logic               wr_en,
  input  logic [STATE_W-1:0] wr_data,
  output logic [STATE_W-1:0] fill
);
  localparam int DW = STATE_W + 1;

  logic [DW-1:0]      fill_x, drained, summed;
  logic [STATE_W-1:0] fill_d;
  logic               upd_en;

  always_comb begin
    fill_x  = {1'b0, fill};
    drained = fill_x;
    if (tick) drained = (drain >= fill_x) ? '0 : fill_x - drain;
    // Both operands are below 2^STATE_W, so the sum fits DW bits.
    summed  = drained + (add_en ? {1'b0, add_amt} : '0);
    if (wr_en)               fill_d = wr_data;
    else if (summed[STATE_W]) fill_d = '1;
    else                      fill_d = summed[STATE_W-1:0];
    upd_en  = wr_en | tick | add_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fill <= '0;
    else if (upd_en) fill <= fill_d;
  end
endmodule

// File: rtl/dlb_policer.sv
module dlb_policer
  import dlb_pol_pkg::*;
#(
  parameter int TICK_DIV = 16,
  parameter int LEN_W    = 14,
  parameter int GAP_W    = 5,
  parameter int RATE_W   = 16,
  parameter int BURST_W  = 7,
  parameter int STATE_W  = 23
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cfg_mode,
  input  logic [GAP_W-1:0]   cfg_gap,
  input  logic               cfg_overshoot,
  input  logic               cfg_dual,
  input  logic               cfg_couple,
  input  logic [RATE_W-1:0]  cfg_pir,
  input  logic [BURST_W-1:0] cfg_pburst,
  input  logic [RATE_W-1:0]  cfg_cir,
  input  logic [BURST_W-1:0] cfg_cburst,
  input  logic               st_wr_peak,
  input  logic               st_wr_commit,
  input  logic [STATE_W-1:0] st_wdata,
  input  logic               frm_valid,
  input  logic [LEN_W-1:0]   frm_len,
  output logic               verdict_valid,
  output logic               verdict_drop,
  output logic               verdict_oop,
  output logic [STATE_W-1:0] peak_fill,
  output logic [STATE_W-1:0] commit_fill
);
  localparam int NB = 2;  // index 0: peak, 1: committed

  // Reset asserted asynchronously, released on the clock.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic               tick;
  logic [STATE_W-1:0] cost, peak_thr, commit_thr;
  logic [STATE_W:0]   peak_drain, commit_drain;

  pol_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick)
  );

  pol_meter #(
    .LEN_W(LEN_W), .GAP_W(GAP_W), .RATE_W(RATE_W),
    .BURST_W(BURST_W), .STATE_W(STATE_W)
  ) u_meter (
    .mode(cfg_mode), .gap(cfg_gap), .len(frm_len),
    .dual(cfg_dual), .couple(cfg_couple),
    .pir(cfg_pir), .cir(cfg_cir),
    .pburst(cfg_pburst), .cburst(cfg_cburst),
    .cost(cost), .peak_thr(peak_thr), .commit_thr(commit_thr),
    .peak_drain(peak_drain), .commit_drain(commit_drain)
  );

  logic [STATE_W-1:0] fill_a [NB];
  logic [STATE_W-1:0] thr_a  [NB];
  logic [STATE_W:0]   drn_a  [NB];
  logic               wr_a   [NB];
  logic               add_a  [NB];
  logic               exc_a  [NB];

  always_comb begin
    thr_a[0] = peak_thr;   thr_a[1] = commit_thr;
    drn_a[0] = peak_drain; drn_a[1] = commit_drain;
    wr_a[0]  = st_wr_peak; wr_a[1]  = st_wr_commit;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NB; gi++) begin : g_bkt
      always_comb begin
        if (cfg_overshoot)
          exc_a[gi] = (fill_a[gi] > thr_a[gi]);
        else
          exc_a[gi] = ({1'b0, fill_a[gi]} + {1'b0, cost}) > {1'b0, thr_a[gi]};
      end

      pol_bucket #(.STATE_W(STATE_W)) u_bkt (
        .clk(clk), .rst_n(rst_sync_n), .tick(tick),
        .drain(drn_a[gi]), .add_en(add_a[gi]), .add_amt(cost),
        .wr_en(wr_a[gi]), .wr_data(st_wdata), .fill(fill_a[gi])
      );
    end
  endgenerate

  logic v_valid_d, v_drop_d, v_oop_d;

  always_comb begin
    add_a[0]  = frm_valid && !exc_a[0];
    add_a[1]  = frm_valid && cfg_dual && !exc_a[0] && !exc_a[1];
    v_valid_d = frm_valid;
    v_drop_d  = frm_valid && exc_a[0];
    v_oop_d   = frm_valid && cfg_dual && !exc_a[0] && exc_a[1];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      verdict_valid <= 1'b0;
      verdict_drop  <= 1'b0;
      verdict_oop   <= 1'b0;
    end else begin
      verdict_valid <= v_valid_d;
      verdict_drop  <= v_drop_d;
      verdict_oop   <= v_oop_d;
    end
  end

  assign peak_fill   = fill_a[0];
  assign commit_fill = fill_a[1];
endmodule

// File: rtl/dlb_policer_chk.sv
module dlb_policer_chk #(
  parameter int STATE_W = 23
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_dual,
  input logic               st_wr_peak,
  input logic               st_wr_commit,
  input logic [STATE_W-1:0] st_wdata,
  input logic               frm_valid,
  input logic               verdict_valid,
  input logic               verdict_drop,
  input logic               verdict_oop,
  input logic [STATE_W-1:0] peak_fill,
  input logic [STATE_W-1:0] commit_fill
);
  assert_verdict_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> $past(frm_valid));

  assert_drop_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_drop |-> (verdict_valid && !verdict_oop));

  assert_oop_dual_R6: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_oop |-> $past(cfg_dual));

  assert_single_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_dual) && !$past(st_wr_commit)) |-> (commit_fill <= $past(commit_fill)));

  assert_drop_no_add_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_drop && !$past(st_wr_peak)) |-> (peak_fill <= $past(peak_fill)));

  assert_peak_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (peak_fill > $past(peak_fill)) |-> ($past(frm_valid) || $past(st_wr_peak)));

  assert_wr_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st_wr_peak) |-> (peak_fill == $past(st_wdata)));

  assert_wr_prio_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st_wr_commit) |-> (commit_fill == $past(st_wdata)));
endmodule

bind dlb_policer dlb_policer_chk #(.STATE_W(STATE_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cfg_dual(cfg_dual),
  .st_wr_peak(st_wr_peak), .st_wr_commit(st_wr_commit), .st_wdata(st_wdata),
  .frm_valid(frm_valid), .verdict_valid(verdict_valid),
  .verdict_drop(verdict_drop), .verdict_oop(verdict_oop),
  .peak_fill(peak_fill), .commit_fill(commit_fill)
);

// File: tb/dlb_policer_test.sv
module dlb_policer_test;
  localparam int D = 16;
  localparam int MAXF = 23'h7FFFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [4:0]  cfg_gap = 5'd0;
  logic        cfg_overshoot = 1'b0, cfg_dual = 1'b0, cfg_couple = 1'b0;
  logic [15:0] cfg_pir = 16'd0, cfg_cir = 16'd0;
  logic [6:0]  cfg_pburst = 7'd0, cfg_cburst = 7'd0;
  logic        st_wr_peak = 1'b0, st_wr_commit = 1'b0;
  logic [22:0] st_wdata = 23'd0;
  logic        frm_valid = 1'b0;
  logic [13:0] frm_len = 14'd0;
  logic        verdict_valid, verdict_drop, verdict_oop;
  logic [22:0] peak_fill, commit_fill;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dlb_policer uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit p, input bit c, input int v);
    @(negedge clk);
    st_wr_peak = p; st_wr_commit = c; st_wdata = 23'(v);
    @(negedge clk);
    st_wr_peak = 1'b0; st_wr_commit = 1'b0;
  endtask

  task automatic frame(input int len);
    @(negedge clk);
    frm_valid = 1'b1; frm_len = 14'(len);
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  function automatic int e_cost(input int m, input int len, input int gap);
    if (m == 0) return len + gap;
    if (m == 1) return len;
    return 10;
  endfunction

  function automatic int e_thr(input int m, input int b);
    int lim, mul;
    if (m == 2) begin lim = 127; mul = 328; end
    else if (m == 3) begin lim = 61; mul = 3; end
    else begin lim = 60; mul = 4096; end
    return ((b > lim) ? lim : b) * mul;
  endfunction

  function automatic bit e_exc(input bit os, input int pre, input int cost, input int thr);
    return os ? (pre > thr) : (pre + cost > thr);
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int bl[7] = '{0, 1, 5, 60, 61, 100, 127};
    int ll[3] = '{64, 1500, 9000};
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(peak_fill == 0 && commit_fill == 0 && !verdict_valid, "R1", int'(peak_fill), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(peak_fill == 0 && commit_fill == 0 && !verdict_valid, "R1", int'(verdict_valid), 0);

    // R2/R3/R4/R5 sweep, rates zero, single bucket
    cfg_gap = 5'd12;
    for (int m = 0; m < 4; m++) begin
      for (int bi = 0; bi < 7; bi++) begin
        for (int os = 0; os < 2; os++) begin
          for (int li = 0; li < 3; li++) begin
            int thr, cost;
            int pl[4];
            cfg_mode = 2'(m); cfg_pburst = 7'(bl[bi]); cfg_overshoot = os[0];
            thr = e_thr(m, bl[bi]);
            cost = e_cost(m, ll[li], 12);
            pl = '{0, thr, thr + 1, (thr > cost) ? thr - cost + 1 : 0};
            for (int pi = 0; pi < 4; pi++) begin
              bit ex;
              int ef;
              wr(1'b1, 1'b0, pl[pi]);
              frame(ll[li]);
              ex = e_exc(os[0], pl[pi], cost, thr);
              ef = ex ? pl[pi] : pl[pi] + cost;
              chk(verdict_valid && verdict_drop == ex && !verdict_oop,
                  "R4 R5 drop", int'(verdict_drop), int'(ex));
              chk(int'(peak_fill) == ef, "R2 R3 peak fill", int'(peak_fill), ef);
            end
          end
        end
      end
    end

    // R2: gap of 31 in mode 0
    cfg_mode = 2'd0; cfg_gap = 5'd31; cfg_pburst = 7'd60; cfg_overshoot = 1'b0;
    wr(1'b1, 1'b0, 0);
    frame(100);
    chk(int'(peak_fill) == 131, "R2 gap", int'(peak_fill), 131);

    // R5: verdict only one cycle
    @(negedge clk);
    chk(!verdict_valid, "R5 strobe width", int'(verdict_valid), 0);

    // R6: dual bucket sweep, mode 1, committed burst 1 (4096)
    cfg_mode = 2'd1; cfg_cburst = 7'd1; cfg_pburst = 7'd60;
    for (int dl = 0; dl < 2; dl++) begin
      int cl[4] = '{0, 3996, 3997, 4097};
      cfg_dual = dl[0];
      for (int ci = 0; ci < 4; ci++) begin
        bit cex;
        int ec;
        wr(1'b1, 1'b1, 0);
        wr(1'b0, 1'b1, cl[ci]);
        frame(100);
        cex = (cl[ci] + 100 > 4096);
        ec = (dl == 1 && !cex) ? cl[ci] + 100 : cl[ci];
        chk(!verdict_drop && verdict_oop == (dl == 1 && cex), "R6 oop",
            int'(verdict_oop), int'(dl == 1 && cex));
        chk(int'(commit_fill) == ec, "R6 commit fill", int'(commit_fill), ec);
      end
    end

    // R9: forced discard by all-ones peak state, dual on, both overshoot settings
    for (int os = 0; os < 2; os++) begin
      cfg_overshoot = os[0];
      wr(1'b0, 1'b1, 0);
      wr(1'b1, 1'b0, MAXF);
      frame(64);
      chk(verdict_drop && !verdict_oop, "R9 forced drop", int'(verdict_drop), 1);
      chk(int'(peak_fill) == MAXF && commit_fill == 0, "R9 state kept",
          int'(peak_fill), MAXF);
    end

    // R9: write wins over a frame in the same cycle
    cfg_dual = 1'b0; cfg_overshoot = 1'b0;
    wr(1'b1, 1'b0, 0);
    @(negedge clk);
    frm_valid = 1'b1; frm_len = 14'd100; st_wr_peak = 1'b1; st_wdata = 23'd5000;
    @(negedge clk);
    frm_valid = 1'b0; st_wr_peak = 1'b0;
    chk(!verdict_drop && int'(peak_fill) == 5000, "R9 write priority", int'(peak_fill), 5000);

    // R7: drain in mode 1 and mode 2, saturating at zero
    cfg_mode = 2'd1; cfg_pir = 16'd7;
    wr(1'b1, 1'b0, 1000);
    repeat (5 * D - 1) @(posedge clk);
    @(negedge clk);
    chk(int'(peak_fill) == 965, "R7 drain", int'(peak_fill), 965);
    wr(1'b1, 1'b0, 10);
    repeat (2 * D - 1) @(posedge clk);
    @(negedge clk);
    chk(peak_fill == 0, "R7 floor", int'(peak_fill), 0);
    cfg_mode = 2'd2; cfg_pir = 16'd3;
    wr(1'b1, 1'b0, 5000);
    repeat (2 * D - 1) @(posedge clk);
    @(negedge clk);
    chk(int'(peak_fill) == 4400, "R7 fine frame scale", int'(peak_fill), 4400);

    // R8: coupling
    for (int cp = 0; cp < 2; cp++) begin
      int ep;
      cfg_mode = 2'd1; cfg_dual = 1'b1; cfg_couple = cp[0];
      cfg_pir = 16'd2; cfg_cir = 16'd3;
      wr(1'b1, 1'b1, 1000);
      repeat (4 * D - 1) @(posedge clk);
      @(negedge clk);
      ep = (cp == 1) ? 980 : 992;
      chk(int'(peak_fill) == ep, "R8 coupled peak drain", int'(peak_fill), ep);
      chk(int'(commit_fill) == 988, "R7 committed drain", int'(commit_fill), 988);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule